// File: doc/BRIEF.md
# Dataless-Way Count Controller

This block decides, once per epoch, how many data ways of a set-associative last-level cache may be switched off. Each switched-off way keeps its tags but loses its data storage. An auxiliary tag array reports every hit it sees, tagged with the recency (stack) position at which the hit landed. The controller keeps one saturating counter per position. Removing the `k` least recently used data ways would turn the hits at the `k` deepest positions into misses. The block therefore sums those hits and weights the sum by the measured average memory latency, which gives an estimate of the cycles that would be lost.

Software writes a degradation bound in steps of 0.1% of the epoch length. When an epoch tick arrives, the controller freezes a copy of the counters and then halves the live counters so that old behaviour fades. It then walks the candidate counts from zero upward, testing one candidate per cycle. After the walk it publishes the largest count whose estimated loss stays inside the bound, and raises a one-cycle done flag. The count is capped so that at least one data way always stays on. The arithmetic compares two integer products, so it needs no divider.

Top module: `ddw_ctrl`

## Requirements
- R1: After reset `ddw_count` is 0, `done` is 0, and the degradation bound register holds 10 (1.0%).
- R2: A cycle with `hit_valid` high adds one to the counter of stack position `hit_pos` (0 = most recent, NWAYS-1 = deepest). A counter at its maximum value 2^CNT_W-1 stays at that value.
- R3: For candidate `k`, the extra-miss estimate is the sum of the frozen counters at positions NWAYS-k to NWAYS-1. Candidate 0 has an estimate of zero.
- R4: Candidate `k` passes when extra × `avg_lat` × 1000 ≤ bound × `epoch_cycles`, where the bound is in units of 0.1%. `avg_lat` and `epoch_cycles` are the values present in the tick cycle.
- R5: The published `ddw_count` is the largest passing candidate in 0..NWAYS-1. It never exceeds NWAYS-1 (13 by default), and it is 13 when every counter is zero.
- R6: `done` is high for exactly one cycle. It rises at the 14th rising edge after the edge that accepts the tick, and `ddw_count` takes its new value at that same edge. At all other times `ddw_count` holds its value.
- R7: The edge that accepts a tick freezes the counter values for evaluation and halves every live counter, rounding down. A hit in the tick cycle is added after the halving.
- R8: A tick that arrives while an evaluation is running is ignored. It produces no extra `done` pulse and does not halve the counters.
- R9: A pulse on `mpd_we` writes `mpd_wdata` into the bound register at any time. Evaluation uses the value held when the tick is accepted, so a write made during an evaluation affects only later epochs.
- R10: Hits that arrive during an evaluation go to the live counters and count in the next epoch, not the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | One auxiliary-tag hit this cycle |
| hit_pos | input | POS_W | Stack position of that hit |
| avg_lat | input | LAT_W | Measured average memory latency in cycles |
| epoch_cycles | input | EPOCH_W | Length of the epoch in cycles |
| epoch_tick | input | 1 | Epoch end; starts an evaluation |
| mpd_we | input | 1 | Write strobe for the degradation bound |
| mpd_wdata | input | MPD_W | New degradation bound, 0.1% units |
| ddw_count | output | POS_W | Number of data ways to switch off |
| done | output | 1 | One-cycle pulse when a new count is published |

## Verification
A wrong counter, snapshot or accumulator shows up only as a different `ddw_count`. It appears 14 cycles after the tick that starts the evaluation, and only when the affected position falls inside the searched prefix. For this reason the bench sets the latency and the bound so that the answer falls between 0 and 13, and compares each answer with a bench model. A counter that wraps or does not halve can stay hidden for a whole epoch, so the bench also looks at the counts published by the epochs that follow. Timing faults in the sequencing show at once as a `done` pulse that is missing, early or repeated.

// File: rtl/ddw_ctrl.sv
module ddw_ctrl #(
  parameter int NWAYS   = 14,
  parameter int CNT_W   = 16,
  parameter int LAT_W   = 10,
  parameter int MPD_W   = 8,
  parameter int EPOCH_W = 20,
  parameter int MPD_RST = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hit_valid,
  input  logic [$clog2(NWAYS)-1:0]     hit_pos,
  input  logic [LAT_W-1:0]             avg_lat,
  input  logic [EPOCH_W-1:0]           epoch_cycles,
  input  logic                         epoch_tick,
  input  logic                         mpd_we,
  input  logic [MPD_W-1:0]             mpd_wdata,
  output logic [$clog2(NWAYS)-1:0]     ddw_count,
  output logic                         done
);
  localparam int POS_W = $clog2(NWAYS);
  localparam int SUM_W = CNT_W + $clog2(NWAYS + 1);
  localparam int LHS_W = SUM_W + LAT_W + 10;
  localparam int RHS_W = MPD_W + EPOCH_W;
  localparam int CMP_W = (LHS_W > RHS_W) ? LHS_W : RHS_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [POS_W-1:0] LAST_K = POS_W'(NWAYS - 1);

  logic [CNT_W-1:0] live [NWAYS];
  logic [CNT_W-1:0] snap [NWAYS];
  logic [MPD_W-1:0] mpd_q;
  logic             busy;
  logic [POS_W-1:0] kidx, best;
  logic [SUM_W-1:0] acc;
  logic [LAT_W-1:0] lat_q;
  logic [RHS_W-1:0] budget;

  wire             start    = epoch_tick & ~busy;
  wire [POS_W-1:0] deep_idx = LAST_K - kidx;
  wire [CMP_W-1:0] loss     = CMP_W'(acc) * CMP_W'(lat_q) * CMP_W'(1000);
  wire             pass     = loss <= CMP_W'(budget);

  for (genvar i = 0; i < NWAYS; i++) begin : g_pos
    wire hit_here = hit_valid && (hit_pos == POS_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live[i] <= '0;
        snap[i] <= '0;
      end else if (start) begin
        snap[i] <= live[i];
        live[i] <= (live[i] >> 1) + CNT_W'(hit_here);
      end else if (hit_here && live[i] != CNT_MAX) begin
        live[i] <= live[i] + 1'b1;
      end
    end

    // R2
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live[i] == CNT_MAX && hit_here && !start) |=> live[i] == CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      mpd_q <= MPD_W'(MPD_RST);
    else if (mpd_we) mpd_q <= mpd_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      kidx      <= '0;
      best      <= '0;
      acc       <= '0;
      lat_q     <= '0;
      budget    <= '0;
      ddw_count <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        kidx   <= '0;
        best   <= '0;
        acc    <= '0;
        lat_q  <= avg_lat;
        budget <= RHS_W'(mpd_q) * RHS_W'(epoch_cycles);
      end else if (busy) begin
        if (pass) best <= kidx;
        acc <= acc + SUM_W'(snap[deep_idx]);
        if (kidx == LAST_K) begin
          busy      <= 1'b0;
          ddw_count <= pass ? kidx : best;
          done      <= 1'b1;
        end else begin
          kidx <= kidx + 1'b1;
        end
      end
    end
  end

  // R5
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ddw_count <= LAST_K);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ddw_count));

  // R6
  done_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R8
  tick_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (epoch_tick && !busy) |=> busy);

  // R3
  acc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> acc == '0);
endmodule

// File: tb/test_ddw_ctrl.sv
module test_ddw_ctrl;
  localparam int NW = 14;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic hit_valid = 0;
  logic [3:0] hit_pos = 0;
  logic [9:0] avg_lat = 0;
  logic [19:0] epoch_cycles = 0;
  logic epoch_tick = 0, mpd_we = 0;
  logic [7:0] mpd_wdata = 0;
  logic [3:0] ddw_count;
  logic done;

  int total = 0, bad = 0;
  int mdl [NW];
  int snapm [NW];
  int mdl_mpd = 10;

  always #5 clk = ~clk;

  ddw_ctrl #(.NWAYS(NW), .CNT_W(CW)) i_ddw_ctrl (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_pos(hit_pos),
    .avg_lat(avg_lat), .epoch_cycles(epoch_cycles), .epoch_tick(epoch_tick),
    .mpd_we(mpd_we), .mpd_wdata(mpd_wdata), .ddw_count(ddw_count), .done(done));

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_k(longint lat, longint cyc, longint mpd);
    longint ext = 0;
    int b = 0;
    for (int k = 0; k < NW; k++) begin
      if (ext * lat * 1000 <= mpd * cyc) b = k;
      ext += snapm[NW - 1 - k];
    end
    return b;
  endfunction

  task automatic send_hit(input int p);
    hit_valid = 1; hit_pos = 4'(p);
    @(negedge clk);
    hit_valid = 0;
    if (mdl[p] < CMAX) mdl[p]++;
  endtask

  task automatic write_mpd(input int v);
    mpd_we = 1; mpd_wdata = 8'(v);
    @(negedge clk);
    mpd_we = 0;
    mdl_mpd = v;
  endtask

  // flags: busy-tick (R8), mpd write during walk (R9), hit during walk (R10), hit at tick (R7)
  task automatic run_epoch(input int lat, input int cyc, input string req,
                           input bit late_tick, input int late_mpd,
                           input bit late_hit, input bit tick_hit);
    int e;
    int last;
    avg_lat = 10'(lat); epoch_cycles = 20'(cyc); epoch_tick = 1;
    if (tick_hit) begin hit_valid = 1; hit_pos = 4'(NW - 1); end
    for (int i = 0; i < NW; i++) begin
      snapm[i] = mdl[i];
      mdl[i] = mdl[i] >> 1;
    end
    if (tick_hit) mdl[NW - 1]++;
    e = exp_k(lat, cyc, mdl_mpd);
    @(negedge clk);
    epoch_tick = 0; hit_valid = 0;
    for (int j = 1; j <= 13; j++) begin
      if (late_tick && j == 5) epoch_tick = 1;
      if (late_mpd >= 0 && j == 3) begin mpd_we = 1; mpd_wdata = 8'(late_mpd); end
      if (late_hit && j == 7) begin hit_valid = 1; hit_pos = 4'(NW - 1); end
      @(negedge clk);
      epoch_tick = 0; mpd_we = 0;
      if (late_mpd >= 0 && j == 3) mdl_mpd = late_mpd;
      if (late_hit && j == 7) begin
        hit_valid = 0;
        if (mdl[NW - 1] < CMAX) mdl[NW - 1]++;
      end
      if (j == 13) check("R6 done not early", done, 0);
    end
    @(negedge clk);
    check("R6 done on 14th edge", done, 1);
    check(req, ddw_count, e);
    @(negedge clk);
    check("R6 done single cycle", done, 0);
    if (late_tick) begin
      last = ddw_count;
      for (int j = 0; j < 20; j++) begin
        @(negedge clk);
        if (done) check("R8 no extra done", done, 0);
      end
      check("R8 count holds", ddw_count, last);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 count after reset", ddw_count, 0);
    check("R1 done after reset", done, 0);

    run_epoch(100, 1000, "R5 all zero gives 13", 0, -1, 0, 0);

    for (int p = 0; p < NW; p++)
      for (int n = 0; n < p + 1; n++) send_hit(p);
    run_epoch(200, 20000, "R1 reset bound 10", 0, -1, 0, 0);

    for (int s = 0; s < 12; s++) begin
      write_mpd(s * 3 + 1);
      for (int p = 0; p < NW; p++)
        for (int n = 0; n < (s * 5 + p * 3) % 17; n++) send_hit(p);
      run_epoch(20 + s * 15, 50000 + s * 20000, "R3 R4 R5 sweep", 0, -1, 0, 0);
    end

    write_mpd(0);
    send_hit(NW - 1);
    run_epoch(50, 100000, "R4 zero bound", 0, -1, 0, 0);

    write_mpd(255);
    run_epoch(1, 1000000, "R5 cap at 13", 0, -1, 0, 0);

    write_mpd(20);
    for (int p = 0; p < NW; p++)
      for (int n = 0; n < 9; n++) send_hit(p);
    run_epoch(100, 80000, "R8 busy tick result", 1, 2, 1, 0);
    run_epoch(100, 80000, "R9 R10 next epoch", 0, -1, 0, 1);
    run_epoch(100, 80000, "R7 halving", 0, -1, 0, 0);

    for (int r = 0; r < 9; r++) run_epoch(10, 1000, "R7 decay", 0, -1, 0, 0);
    write_mpd(1);
    for (int n = 0; n < 300; n++) send_hit(NW - 1);
    for (int n = 0; n < 5; n++) send_hit(NW - 2);
    run_epoch(1, 255000, "R2 saturation", 0, -1, 0, 0);
    check("R2 saturated answer", ddw_count, 1);
    run_epoch(1, 127000, "R2 R7 halved saturated", 0, -1, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule